// File: doc/BRIEF.md
# Pulse Charge and Time Extractor

This block takes one channel of digitized waveform samples and extracts pulses from it. Each accepted sample comes with a valid strobe. The block forms a two-tap moving sum of the samples and then takes the difference between consecutive sums. A hit region is a run of consecutive samples in which that difference exceeds a programmable threshold. When a region closes, the block reports three results:

- the charge of the pulse, as the raw integral with the pedestal removed;
- a fixed-point arrival time;
- a flag that marks a region cut off by the end of the processing window.

The pedestal is the mean of a power-of-two number of samples. These samples sit a programmable gap before the start of the hit. The integer part of the time is the index of the peak sample inside the window. The fractional part comes from a 256-entry table. The table is addressed by a quantized ratio that is formed from the two neighbours of the peak. Samples are grouped into windows of a programmable length, and the history is cleared at every window boundary.

Top module: `pulse_qt`

## Requirements
- R1: The sample index counts accepted samples from 0 up to `win_last` and then returns to 0. A new window begins after the sample at `win_last`. Samples with index 0 or 1 never open a region. Positions before the start of the window read as zero.
- R2: For a sample x[n], the detector value is d = (x[n]+x[n-1]) - (x[n-1]+x[n-2]). A sample belongs to a hit region when d > `thr`, a strict comparison of signed d against unsigned `thr`. A region is a maximal run of such samples.
- R3: A region closes at the first accepted sample whose d does not exceed `thr`. That closing sample is not part of the region. `pls_vld` is high for exactly one cycle, in the cycle after the closing sample is accepted. Outside that cycle, `pls_charge`, `pls_time` and `pls_trunc` hold their last values.
- R4: For a region starting at index s, the pedestal is floor(S/4). S is the sum of the samples at indices s-`ped_gap`-4 through s-`ped_gap`-1. Indices below 0 count as zero.
- R5: `pls_charge` is the sum of the raw samples in the region minus pedestal × region length. It is in two's complement.
- R6: The peak is the largest sample in the region, and the earliest one is taken on ties. `pls_time` = 16 × (peak index) + f, where f is the 4-bit fraction. f = 0 denotes half a sample before the peak sample.
- R7: Let ua = max(peak-left, 0), ub = max(peak-right, 0) and S = ua+ub. Then q = 128 when S = 0, and otherwise q = min(255, floor(256·ua/S)). f = floor((15q+128)/256).
- R8: The left neighbour is the sample just before the peak. The right neighbour is the sample just after the peak, which is the closing sample when the peak ends the region. When the window ends on the peak, the right neighbour equals the peak.
- R9: A region that contains the sample at index `win_last` closes there, and `pls_trunc` is 1. This includes a region of length one. For every other pulse, `pls_trunc` is 0.
- R10: Cycles with `smp_vld` low change nothing: no index advance, no history shift and no region update.
- R11: After reset, `pls_vld`, `pls_charge`, `pls_time` and `pls_trunc` are all 0, and the sample index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | W | Unsigned sample value |
| thr | input | W | Detector threshold |
| ped_gap | input | GW | Distance in samples between the pedestal run and the hit start |
| win_last | input | IW | Index of the last sample in a window |
| pls_vld | output | 1 | One-cycle pulse-report strobe |
| pls_charge | output | W+IW+2 | Pedestal-corrected charge, signed |
| pls_time | output | IW+4 | Peak index with a 4-bit fraction |
| pls_trunc | output | 1 | The region was closed by the end of the window |

## Verification
The closing of a region and the end of a window can fall on the same sample. In that case the last sample is part of the region, so it must be integrated and taken as a possible peak. The block must also serve as the right neighbour, and the index must wrap, all in one cycle.

The bench provokes this case in three ways:
- rising edges placed on the final sample of a window;
- a region of length one made of the last sample alone;
- random windows, some short, in which pulses land anywhere.

A bench model keeps each window's samples in an array. It derives the expected charge, time and truncation flag of every pulse from R2 to R9, and the bench compares every reported pulse with that model.

// File: rtl/pqt_pkg.sv
package pqt_pkg;
  localparam int FRAC_W = 4;
  localparam int Q_W    = 8;
  localparam int Q_MID  = 1 << (Q_W - 1);

  // Fraction of a sample from the quantized neighbour ratio (R7).
  function automatic logic [FRAC_W-1:0] frac_of(input logic [Q_W-1:0] q);
    logic [15:0] t;
    t = 16'(q) * 16'd15 + 16'd128;
    return t[11:8];
  endfunction
endpackage

// File: rtl/pqt_front.sv
module pqt_front #(
  parameter int W  = 12,
  parameter int IW = 8,
  parameter int GW = 3,
  parameter int PW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [W-1:0]        smp,
  input  logic [IW-1:0]       win_last,
  input  logic [GW-1:0]       ped_gap,
  output logic [IW-1:0]       idx,
  output logic                last,
  output logic                arm,
  output logic signed [W+1:0] diff,
  output logic [W-1:0]        prev1,
  output logic [W-1:0]        ped_mean
);
  localparam int P    = 1 << PW;
  localparam int GMAX = (1 << GW) - 1;
  localparam int HD   = GMAX + P;
  localparam int SW   = W + PW;

  logic [IW-1:0] idx_q, idx_n;
  logic [W-1:0]  hist_q [HD];
  logic [W-1:0]  hist_n [HD];
  logic [W:0]    sum1_q, sum1_n, sum0;
  logic [SW-1:0] ped_sum;

  assign idx   = idx_q;
  assign last  = (idx_q == win_last);
  assign arm   = (idx_q >= IW'(2));
  assign prev1 = hist_q[0];

  // two-tap moving sum, then one-sample difference of the sums
  assign sum0 = {1'b0, smp} + {1'b0, hist_q[0]};
  assign diff = $signed({1'b0, sum0}) - $signed({1'b0, sum1_q});

  // pedestal run selected by the gap
  always_comb begin
    ped_sum = '0;
    for (int j = 0; j < P; j++) begin
      ped_sum = ped_sum + SW'(hist_q[int'(ped_gap) + j]);
    end
  end
  assign ped_mean = ped_sum[SW-1:PW];

  always_comb begin
    idx_n  = idx_q;
    sum1_n = sum1_q;
    for (int k = 0; k < HD; k++) hist_n[k] = hist_q[k];
    if (smp_vld) begin
      if (last) begin
        idx_n  = '0;
        sum1_n = '0;
        for (int k = 0; k < HD; k++) hist_n[k] = '0;
      end else begin
        idx_n     = idx_q + IW'(1);
        sum1_n    = sum0;
        hist_n[0] = smp;
        for (int k = 1; k < HD; k++) hist_n[k] = hist_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sum1_q <= '0;
      for (int k = 0; k < HD; k++) hist_q[k] <= '0;
    end else begin
      idx_q  <= idx_n;
      sum1_q <= sum1_n;
      for (int k = 0; k < HD; k++) hist_q[k] <= hist_n[k];
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(idx_q) && $stable(sum1_q)); // R10
endmodule

// File: rtl/pqt_region.sv
module pqt_region #(
  parameter int W  = 12,
  parameter int IW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld,
  input  logic [W-1:0]           smp,
  input  logic [IW-1:0]          idx,
  input  logic                   last,
  input  logic                   arm,
  input  logic signed [W+1:0]    diff,
  input  logic [W-1:0]           thr,
  input  logic [W-1:0]           prev1,
  input  logic [W-1:0]           ped_mean,
  output logic                   cls,
  output logic                   cls_trunc,
  output logic signed [W+IW+1:0] cls_charge,
  output logic [IW-1:0]          cls_idx,
  output logic [W-1:0]           cls_pk,
  output logic [W-1:0]           cls_left,
  output logic [W-1:0]           cls_right
);
  localparam int AW = W + IW + 1;
  localparam int LW = IW + 1;

  logic          open_q, open_n;
  logic [AW-1:0] acc_q, acc_n, prod;
  logic [LW-1:0] len_q, len_n;
  logic [W-1:0]  ped_q, ped_n;
  logic [W-1:0]  pk_q, pk_n, pkl_q, pkl_n, pkr_q, pkr_n;
  logic [IW-1:0] pki_q, pki_n;
  logic          needr_q, needr_n;
  logic          hot;

  assign hot = arm && (diff > $signed({2'b00, thr}));

  always_comb begin
    open_n  = open_q;
    acc_n   = acc_q;
    len_n   = len_q;
    ped_n   = ped_q;
    pk_n    = pk_q;
    pki_n   = pki_q;
    pkl_n   = pkl_q;
    pkr_n   = pkr_q;
    needr_n = needr_q;
    cls       = 1'b0;
    cls_trunc = 1'b0;
    if (smp_vld) begin
      if (!open_q && hot) begin
        acc_n   = AW'(smp);
        len_n   = LW'(1);
        ped_n   = ped_mean;
        pk_n    = smp;
        pki_n   = idx;
        pkl_n   = prev1;
        needr_n = 1'b1;
      end else if (open_q) begin
        if (hot) begin
          acc_n = acc_q + AW'(smp);
          len_n = len_q + LW'(1);
        end
        if (hot && (smp > pk_q)) begin
          pk_n    = smp;
          pki_n   = idx;
          pkl_n   = prev1;
          needr_n = 1'b1;
        end else if (needr_q) begin
          pkr_n   = smp;
          needr_n = 1'b0;
        end
      end
      cls       = (open_q && !hot) || (hot && last);
      cls_trunc = hot && last;
      open_n    = hot && !last;
    end
  end

  assign prod       = AW'(ped_n) * AW'(len_n);
  assign cls_charge = $signed({1'b0, acc_n}) - $signed({1'b0, prod});
  assign cls_idx    = pki_n;
  assign cls_pk     = pk_n;
  assign cls_left   = pkl_n;
  assign cls_right  = needr_n ? pk_n : pkr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      acc_q   <= '0;
      len_q   <= '0;
      ped_q   <= '0;
      pk_q    <= '0;
      pki_q   <= '0;
      pkl_q   <= '0;
      pkr_q   <= '0;
      needr_q <= 1'b0;
    end else begin
      open_q  <= open_n;
      acc_q   <= acc_n;
      len_q   <= len_n;
      ped_q   <= ped_n;
      pk_q    <= pk_n;
      pki_q   <= pki_n;
      pkl_q   <= pkl_n;
      pkr_q   <= pkr_n;
      needr_q <= needr_n;
    end
  end

  AST_OPEN_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> (idx >= IW'(3))); // R1
  AST_PEAK_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (pki_q < idx)); // R6
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (len_q != '0)); // R2
endmodule

// File: rtl/pqt_interp.sv
module pqt_interp #(
  parameter int W = 12
) (
  input  logic [W-1:0]               pk,
  input  logic [W-1:0]               left,
  input  logic [W-1:0]               right,
  output logic [pqt_pkg::FRAC_W-1:0] frac
);
  import pqt_pkg::*;
  localparam int NW = W + Q_W;

  logic [W-1:0]       ua, ub;
  logic [W:0]         s;
  logic [NW-1:0]      num, den, quot;
  logic [Q_W-1:0]     q;
  logic [FRAC_W-1:0]  lut [1 << Q_W];

  for (genvar g = 0; g < (1 << Q_W); g++) begin : g_lut
    assign lut[g] = frac_of(Q_W'(g));
  end

  assign ua   = (pk > left)  ? (pk - left)  : '0;
  assign ub   = (pk > right) ? (pk - right) : '0;
  assign s    = {1'b0, ua} + {1'b0, ub};
  assign num  = {ua, {Q_W{1'b0}}};
  assign den  = (s == '0) ? NW'(1) : NW'(s);
  assign quot = num / den;

  always_comb begin
    if (s == '0)                         q = Q_W'(Q_MID);
    else if (quot > NW'((1 << Q_W) - 1)) q = '1;
    else                                 q = quot[Q_W-1:0];
  end

  assign frac = lut[q];
endmodule

// File: rtl/pulse_qt.sv
module pulse_qt #(
  parameter int W  = 12,
  parameter int IW = 8,
  parameter int GW = 3,
  parameter int PW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld,
  input  logic [W-1:0]           smp,
  input  logic [W-1:0]           thr,
  input  logic [GW-1:0]          ped_gap,
  input  logic [IW-1:0]          win_last,
  output logic                   pls_vld,
  output logic signed [W+IW+1:0] pls_charge,
  output logic [IW+3:0]          pls_time,
  output logic                   pls_trunc
);
  import pqt_pkg::*;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [IW-1:0]          idx;
  logic                   last, arm;
  logic signed [W+1:0]    diff;
  logic [W-1:0]           prev1, ped_mean;
  logic                   cls, cls_trunc;
  logic signed [W+IW+1:0] cls_charge;
  logic [IW-1:0]          cls_idx;
  logic [W-1:0]           cls_pk, cls_left, cls_right;
  logic [FRAC_W-1:0]      frac;

  pqt_front #(.W(W), .IW(IW), .GW(GW), .PW(PW)) u_front (
    .clk(clk), .rst_n(rst_i_n), .smp_vld(smp_vld), .smp(smp),
    .win_last(win_last), .ped_gap(ped_gap), .idx(idx), .last(last),
    .arm(arm), .diff(diff), .prev1(prev1), .ped_mean(ped_mean));

  pqt_region #(.W(W), .IW(IW)) u_region (
    .clk(clk), .rst_n(rst_i_n), .smp_vld(smp_vld), .smp(smp), .idx(idx),
    .last(last), .arm(arm), .diff(diff), .thr(thr), .prev1(prev1),
    .ped_mean(ped_mean), .cls(cls), .cls_trunc(cls_trunc),
    .cls_charge(cls_charge), .cls_idx(cls_idx), .cls_pk(cls_pk),
    .cls_left(cls_left), .cls_right(cls_right));

  pqt_interp #(.W(W)) u_interp (
    .pk(cls_pk), .left(cls_left), .right(cls_right), .frac(frac));

  logic                   vld_n, trunc_n;
  logic signed [W+IW+1:0] charge_n;
  logic [IW+3:0]          time_n;

  always_comb begin
    vld_n    = 1'b0;
    trunc_n  = pls_trunc;
    charge_n = pls_charge;
    time_n   = pls_time;
    if (smp_vld && cls) begin
      vld_n    = 1'b1;
      trunc_n  = cls_trunc;
      charge_n = cls_charge;
      time_n   = {cls_idx, frac};
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pls_vld    <= 1'b0;
      pls_trunc  <= 1'b0;
      pls_charge <= '0;
      pls_time   <= '0;
    end else begin
      pls_vld    <= vld_n;
      pls_trunc  <= trunc_n;
      pls_charge <= charge_n;
      pls_time   <= time_n;
    end
  end

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pls_vld |-> $stable(pls_charge) && $stable(pls_time)); // R3
  AST_TRUNC_WRAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pls_vld && pls_trunc) |-> (idx == '0)); // R9
  AST_FLAT_MID: assert property (@(posedge clk) disable iff (!rst_i_n)
    (smp_vld && cls && (cls_left == cls_right)) |=> (pls_time[3:0] == 4'd8)); // R7
endmodule

// File: tb/pulse_qt_test.sv
module pulse_qt_test;
  localparam int W = 12, IW = 8, GW = 3, PW = 2;
  localparam int P = 1 << PW;

  logic                   clk, rst_n, smp_vld;
  logic [W-1:0]           smp, thr;
  logic [GW-1:0]          ped_gap;
  logic [IW-1:0]          win_last;
  logic                   pls_vld, pls_trunc;
  logic signed [W+IW+1:0] pls_charge;
  logic [IW+3:0]          pls_time;

  pulse_qt #(.W(W), .IW(IW), .GW(GW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .thr(thr),
    .ped_gap(ped_gap), .win_last(win_last), .pls_vld(pls_vld),
    .pls_charge(pls_charge), .pls_time(pls_time), .pls_trunc(pls_trunc));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int charge; int tm; bit tr; } exp_t;
  exp_t eq[$];
  int checks = 0, errs = 0, exp_cnt = 0, got_cnt = 0;
  int w[256];
  int n = 0, st = 0, thr_v = 0, gap_v = 0, last_v = 0;
  bit open_r = 0, run = 0, seen = 0, done = 0;
  int h_charge = 0, h_tm = 0;
  bit h_tr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected pulse for region s..e from the requirements
  task automatic emit(input int s, input int e, input bit tr);
    int sum, psum, ped, pi, pk, a, b, ua, ub, ss, q, f;
    exp_t x;
    sum = 0;
    for (int k = s; k <= e; k++) sum += w[k];
    psum = 0;
    for (int k = s - gap_v - P; k < s - gap_v; k++) if (k >= 0) psum += w[k];
    ped = psum / P;
    pi = s; pk = w[s];
    for (int k = s; k <= e; k++) if (w[k] > pk) begin pk = w[k]; pi = k; end
    a = (pi >= 1) ? w[pi-1] : 0;
    if (pi < e)  b = w[pi+1];
    else if (tr) b = pk;
    else         b = w[e+1];
    ua = (pk > a) ? pk - a : 0;
    ub = (pk > b) ? pk - b : 0;
    ss = ua + ub;
    if (ss == 0) q = 128;
    else begin q = (ua * 256) / ss; if (q > 255) q = 255; end
    f = (q * 15 + 128) >> 8;
    x.charge = sum - ped * (e - s + 1);
    x.tm = pi * 16 + f;
    x.tr = tr;
    eq.push_back(x);
    exp_cnt++;
  endtask

  task automatic model_sample(input int x);
    bit hot;
    hot = 0;
    if (n >= 2) hot = (x - w[n-2]) > thr_v;
    w[n] = x;
    if (hot && !open_r) begin open_r = 1; st = n; end
    if (open_r && !hot) begin emit(st, n - 1, 0); open_r = 0; end
    else if (open_r && n == last_v) begin emit(st, n, 1); open_r = 0; end
    n = (n == last_v) ? 0 : n + 1;
  endtask

  task automatic send(input int x);
    @(negedge clk);
    smp_vld = 1'b1;
    smp = W'(x);
    model_sample(x);
  endtask

  task automatic idle();
    @(negedge clk);
    smp_vld = 1'b0;
    smp = W'($urandom % 4096);
  endtask

  task automatic cfg(input int l, input int t, input int g);
    last_v = l; thr_v = t; gap_v = g;
    win_last = IW'(l); thr = W'(t); ped_gap = GW'(g);
  endtask

  task automatic check_counts(input string tag);
    repeat (3) idle();
    chk(got_cnt == exp_cnt && eq.size() == 0, tag, got_cnt, exp_cnt);
  endtask

  // pulse monitor away from the active edge
  always @(negedge clk) begin
    if (run) begin
      if (pls_vld) begin
        got_cnt++;
        if (eq.size() == 0) begin
          chk(0, "R3 unexpected pulse", 1, 0);
        end else begin
          exp_t e;
          e = eq.pop_front();
          chk(int'(pls_charge) == e.charge, "R4 R5 charge", int'(pls_charge), e.charge);
          chk(int'(pls_time) == e.tm, "R6 R7 R8 time", int'(pls_time), e.tm);
          chk(pls_trunc == e.tr, "R9 trunc", pls_trunc, e.tr);
        end
        seen = 1;
        h_charge = int'(pls_charge); h_tm = int'(pls_time); h_tr = pls_trunc;
      end else if (seen) begin
        chk(int'(pls_charge) == h_charge && int'(pls_time) == h_tm && pls_trunc == h_tr,
            "R3 hold", int'(pls_charge), h_charge);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int base, amp, rise, left, k, x, idl;
    void'($urandom(32'd7421));
    rst_n = 1'b0; smp_vld = 1'b0; smp = '0;
    cfg(31, 40, 2);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pls_vld == 0 && pls_charge == 0 && pls_time == 0 && pls_trunc == 0,
        "R11 reset outputs", pls_vld, 0);
    run = 1;

    // Directed window: symmetric pulse (q=128) and rising edge ending the window
    for (int i = 0; i < 32; i++) begin
      case (i)
        10: x = 300;  11: x = 700;  12: x = 900;  13: x = 700;  14: x = 300;
        30: x = 1000; 31: x = 2000;
        default: x = 100;
      endcase
      send(x);
    end
    check_counts("R2 R9 directed edge");

    // Directed window: large opening samples, tied peak, single-sample truncation
    for (int i = 0; i < 32; i++) begin
      case (i)
        0, 1: x = 3000;
        15: x = 500; 16: x = 900; 17: x = 900; 18: x = 400;
        31: x = 2000;
        default: x = 100;
      endcase
      send(x);
    end
    check_counts("R1 R6 R9 directed start");

    // Directed window with idle cycles between samples
    cfg(15, 30, 0);
    for (int i = 0; i < 16; i++) begin
      x = (i == 6) ? 800 : (i == 7) ? 1500 : (i == 8) ? 600 : 200;
      send(x);
      idle(); idle();
    end
    check_counts("R10 idle gaps");

    // Random windows
    for (int ph = 0; ph < 8; ph++) begin
      case (ph % 4)
        0: k = 15; 1: k = 63; 2: k = 127; default: k = 255;
      endcase
      cfg(k, 20 + int'($urandom % 60), int'($urandom % 8));
      idl = ph % 3;
      base = 150 + int'($urandom % 400);
      left = 0; amp = 0; rise = 1;
      for (int win = 0; win < 3000 / (k + 1) + 1; win++) begin
        for (int i = 0; i <= k; i++) begin
          if (left == 0 && ($urandom % 20) == 0) begin
            amp = 200 + int'($urandom % 2800);
            rise = 1 + int'($urandom % 3);
            left = rise + 6;
          end
          x = base + int'($urandom % 16);
          if (left > 0) begin
            k = rise + 6 - left;
            if (k < rise) x += amp * (k + 1) / rise;
            else          x += amp >> (k - rise);
            left--;
            k = last_v;
          end
          if (x > 4095) x = 4095;
          send(x);
          if (idl != 0 && ($urandom % 4) == 0) idle();
        end
      end
      check_counts("R2 R10 random pulse count");
    end

    run = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule